// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is one clocked access port onto an on-chip word memory whose words are split into independently selectable lanes (by default two lanes of 9 bits, an 18-bit word). On each rising clock edge the port samples a pair of chip enables of opposite polarity, a read/write strobe, an address and one active-low select per lane. It then writes or reads only the lanes that are selected. The memory itself is an internal register array whose depth is a parameter. The address comes from outside the block.

Output drive is reported per lane as a drive flag instead of a real tristate pad. Read data on a lane that is not driven reads as zero. Two inputs gate the drive flags with no clock involved: an active-low output enable and an active-high sleep input, with sleep taking precedence over everything. A static mode input sets the read latency: data follows one edge after the sampling edge (flow-through) or two edges after it (pipelined). In pipelined mode the drive flags travel through the extra register together with the data.

Data moves as a plain synchronous memory access and there is no valid/ready handshake. The port accepts an access on every clock edge and never applies back-pressure. A reader must take the data in the fixed cycle that the latency mode sets.

Top module: `lanestore_port`

## Requirements
- R1: An access takes place only when `ce_lo_n` is 0 and `ce_hi` is 1 at the clock edge. Any other combination neither writes nor drives any lane.
- R2: Lane 0 is `wdata`/`rdata` bits 8:0 and is selected by `lane_sel_n[0]`. Lane 1 is bits 17:9 and is selected by `lane_sel_n[1]`. A select bit of 0 selects its lane, and any combination of lanes may be accessed in one cycle.
- R3: With `lane_sel_n` = 2'b11, an enabled access writes nothing and drives nothing.
- R4: A write (`rw` = 0) stores only the selected lanes of `wdata`, the other lanes keep their contents, and a write drives no lane.
- R5: A read (`rw` = 1) raises `lane_drv` only for selected lanes. `rdata` bits of lanes that are not driven are 0.
- R6: While `oe_n` is 1, `lane_drv` is 0 and `rdata` is 0, with no clock edge needed.
- R7: While `sleep` is 1, `lane_drv` and `rdata` are 0 with no clock edge needed, and an access sampled while `sleep` is 1 neither writes nor reads.
- R8: With `pipe_mode` = 0, read data and drive flags appear in the cycle that follows the sampling edge.
- R9: With `pipe_mode` = 1, read data and drive flags appear one cycle later than in R8, with the flags aligned to the data.
- R10: During reset and after it, no lane is driven until a read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the access |
| rst_n | input | 1 | Active-low reset of the read path registers |
| ce_lo_n | input | 1 | Chip enable, active low |
| ce_hi | input | 1 | Chip enable, active high |
| rw | input | 1 | 1 = read, 0 = write |
| lane_sel_n | input | LANES | Per-lane select, active low |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Output enable, active low, not clocked |
| sleep | input | 1 | Sleep, active high, not clocked, overrides all |
| pipe_mode | input | 1 | 0 = flow-through, 1 = pipelined read |
| rdata | output | LANES*LANE_W | Read data, zero on undriven lanes |
| lane_drv | output | LANES | Per-lane drive flag |

## Verification
The bench builds the port with two 9-bit lanes and a depth of 32 words. This keeps the top row (address 31) cheap to reach, so both ends of the address range are written and read back. The same instance runs in both latency modes by switching `pipe_mode` between idle stretches. This covers back-to-back reads in each mode, and a read whose output enable or sleep changes between the sampling edge and the cycle in which the data appears.

// File: rtl/lanestore_pkg.sv
package lanestore_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  // Decide what one sampled set of controls does to the array.
  function automatic acc_kind_e decode_access(input logic ce_lo_n,
                                              input logic ce_hi,
                                              input logic rw,
                                              input logic sleep,
                                              input logic any_lane);
    if (ce_lo_n || !ce_hi || sleep || !any_lane) return ACC_IDLE;
    return rw ? ACC_READ : ACC_WRITE;
  endfunction

endpackage

// File: rtl/lanestore_array.sv
module lanestore_array #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] wr_lane,
  input  logic             rd_fire,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rd_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_lane[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_fire) rd_q <= mem[addr];
    end

    assign rd_word[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/lanestore_rdpipe.sv
module lanestore_rdpipe #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] rd_lane,
  input  logic [W-1:0]     s1_word,
  input  logic             pipe_mode,
  output logic [LANES-1:0] out_lane,
  output logic [W-1:0]     out_word
);

  logic [LANES-1:0] s1_lane;
  logic [LANES-1:0] s2_lane;
  logic [W-1:0]     s2_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_lane <= '0;
      s2_lane <= '0;
      s2_word <= '0;
    end else begin
      s1_lane <= rd_lane;
      s2_lane <= s1_lane;
      s2_word <= s1_word;
    end
  end

  assign out_lane = pipe_mode ? s2_lane : s1_lane;
  assign out_word = pipe_mode ? s2_word : s1_word;

  // R9
  pipe_flag_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && rd_lane == '0) |=> ##1 (out_lane == '0));

endmodule

// File: rtl/lanestore_drive.sv
module lanestore_drive #(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] out_lane,
  input  logic [W-1:0]     out_word,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [LANES-1:0] lane_drv,
  output logic [W-1:0]     rdata
);

  logic drive_ok;
  assign drive_ok = !oe_n && !sleep;

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    assign lane_drv[g] = out_lane[g] && drive_ok;
    assign rdata[g*LANE_W +: LANE_W] =
      lane_drv[g] ? out_word[g*LANE_W +: LANE_W] : '0;
  end

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_drv == '0 && rdata == '0));

  // R6
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (lane_drv == '0 && rdata == '0));

endmodule

// File: rtl/lanestore_port.sv
module lanestore_port
  import lanestore_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANE_W * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_lo_n,
  input  logic             ce_hi,
  input  logic             rw,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic [AW-1:0]    addr,
  input  logic [W-1:0]     wdata,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic             pipe_mode,
  output logic [W-1:0]     rdata,
  output logic [LANES-1:0] lane_drv
);

  acc_kind_e        kind;
  logic [LANES-1:0] lane_hit;
  logic [LANES-1:0] wr_lane;
  logic [LANES-1:0] rd_lane;
  logic             rd_fire;
  logic [W-1:0]     s1_word;
  logic [LANES-1:0] out_lane;
  logic [W-1:0]     out_word;

  assign kind     = decode_access(ce_lo_n, ce_hi, rw, sleep, ~&lane_sel_n);
  assign lane_hit = ~lane_sel_n;
  assign rd_fire  = (kind == ACC_READ);
  assign wr_lane  = (kind == ACC_WRITE) ? lane_hit : '0;
  assign rd_lane  = rd_fire ? lane_hit : '0;

  lanestore_array #(.LANE_W(LANE_W), .LANES(LANES), .DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lane (wr_lane),
    .rd_fire (rd_fire),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (s1_word)
  );

  lanestore_rdpipe #(.LANE_W(LANE_W), .LANES(LANES)) u_rdpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_lane   (rd_lane),
    .s1_word   (s1_word),
    .pipe_mode (pipe_mode),
    .out_lane  (out_lane),
    .out_word  (out_word)
  );

  lanestore_drive #(.LANE_W(LANE_W), .LANES(LANES)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_lane (out_lane),
    .out_word (out_word),
    .oe_n     (oe_n),
    .sleep    (sleep),
    .lane_drv (lane_drv),
    .rdata    (rdata)
  );

  // R1
  deselect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_lo_n || !ce_hi) |-> (wr_lane == '0 && rd_lane == '0));

  // R7
  sleep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (wr_lane == '0));

  // R4
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lo_n && ce_hi && !rw && !pipe_mode) |=> (lane_drv == '0));

  // R5
  read_sel_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_lo_n && ce_hi && rw && !pipe_mode) |=> ((lane_drv & $past(lane_sel_n)) == '0));

  // R3
  no_lane_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&lane_sel_n && !pipe_mode) |=> (lane_drv == '0));

endmodule

// File: tb/lanestore_port_tb.sv
module lanestore_port_tb;

  localparam int DEP = 32;
  localparam int AW  = $clog2(DEP);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_lo_n = 1'b1, ce_hi = 1'b0, rw = 1'b1;
  logic [1:0]  lane_sel_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [17:0] wdata = '0;
  logic        oe_n = 1'b0, sleep = 1'b0, pipe_mode = 1'b0;
  logic [17:0] rdata;
  logic [1:0]  lane_drv;

  logic        tb_oe_n = 1'b0, tb_sleep = 1'b0;
  logic [17:0] model [DEP];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [17:0] q_data[$];
  logic [1:0]  q_drv[$];
  int          q_due[$];
  string       q_tag[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lanestore_port #(.LANE_W(9), .LANES(2), .DEPTH(DEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .rw(rw),
    .lane_sel_n(lane_sel_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .sleep(sleep), .pipe_mode(pipe_mode), .rdata(rdata), .lane_drv(lane_drv)
  );

  task automatic check(input bit ok, input string tag, input logic [19:0] act,
                       input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual drv/data=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one call per clock cycle; pushes the expected output item
  task automatic access(input logic lo_n, input logic hi, input logic rw_i,
                        input logic [1:0] sel, input int a,
                        input logic [17:0] d, input string tag);
    logic en;
    logic [17:0] e_data;
    logic [1:0]  e_drv;
    @(posedge clk); #1;
    ce_lo_n = lo_n; ce_hi = hi; rw = rw_i; lane_sel_n = sel;
    addr = AW'(a); wdata = d; oe_n = tb_oe_n; sleep = tb_sleep;
    en = !lo_n && hi && !tb_sleep && (sel != 2'b11);
    e_data = '0; e_drv = '0;
    if (en && !rw_i) begin
      if (!sel[0]) model[a][8:0]  = d[8:0];
      if (!sel[1]) model[a][17:9] = d[17:9];
    end
    if (en && rw_i) begin
      e_drv = ~sel;
      e_data = model[a];
    end
    q_data.push_back(e_data);
    q_drv.push_back(e_drv);
    q_due.push_back(cyc + 1 + int'(pipe_mode));
    q_tag.push_back(tag);
  endtask

  task automatic wr(input int a, input logic [1:0] sel, input logic [17:0] d,
                    input string tag);
    access(1'b0, 1'b1, 1'b0, sel, a, d, tag);
  endtask

  task automatic rd(input int a, input logic [1:0] sel, input string tag);
    access(1'b0, 1'b1, 1'b1, sel, a, 18'h0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) access(1'b1, 1'b0, 1'b1, 2'b11, 0, 18'h0, "idle");
  endtask

  // monitor: pops every item due this cycle, compares mid-cycle
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [1:0]  ed;
      logic [17:0] ev;
      ed = q_drv[0] & {2{!oe_n && !sleep}};
      ev = {ed[1] ? q_data[0][17:9] : 9'h0, ed[0] ? q_data[0][8:0] : 9'h0};
      check(q_due[0] == cyc && lane_drv == ed && rdata == ev, q_tag[0],
            {lane_drv, rdata}, {ed, ev});
      void'(q_data.pop_front()); void'(q_drv.pop_front());
      void'(q_due.pop_front());  void'(q_tag.pop_front());
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEP; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R10: nothing driven during reset
    check(lane_drv == 2'b00 && rdata == '0, "R10 reset", {lane_drv, rdata}, 20'h0);
    rst_n = 1'b1;
    idle(2);

    // fill rows, both lanes, incl. both ends of the range (R2, R4)
    for (int i = 0; i < 6; i++) wr(i, 2'b00, 18'(32'h1_2345 * (i + 1)), "R4 fill");
    wr(DEP - 1, 2'b00, 18'h2_AB55, "R4 top row");
    // R8 flow-through reads, every lane combination (R2, R3, R5)
    rd(0, 2'b00, "R8 read both");
    rd(1, 2'b10, "R2 lower lane only");
    rd(2, 2'b01, "R2 upper lane only");
    rd(3, 2'b11, "R3 no lane read");
    rd(DEP - 1, 2'b00, "R5 top row");
    // lane-selective writes keep the other lane (R4)
    wr(3, 2'b10, 18'h3_FFFF, "R4 lower write");
    wr(4, 2'b01, 18'h0_0000, "R4 upper write");
    rd(3, 2'b00, "R4 lower changed only");
    rd(4, 2'b00, "R4 upper changed only");
    // R3: enabled write with no lane selected
    wr(5, 2'b11, 18'h1_1111, "R3 write no lane");
    rd(5, 2'b00, "R3 contents kept");
    // R1: each deselecting combination
    access(1'b1, 1'b1, 1'b0, 2'b00, 0, 18'h0_0F0F, "R1 ce_lo_n high");
    access(1'b0, 1'b0, 1'b0, 2'b00, 0, 18'h0_0F0F, "R1 ce_hi low");
    access(1'b1, 1'b0, 1'b1, 2'b00, 0, 18'h0, "R1 read deselected");
    rd(0, 2'b00, "R1 contents kept");
    // R6: output enable high, and raised after the sampling edge
    tb_oe_n = 1'b1;
    rd(1, 2'b00, "R6 oe high");
    tb_oe_n = 1'b0;
    rd(2, 2'b00, "R6 read before oe rises");
    tb_oe_n = 1'b1;
    rd(1, 2'b00, "R6 oe async gate");
    tb_oe_n = 1'b0;
    rd(1, 2'b00, "R6 oe released");
    // R7: sleep blocks writes and reads, and gates asynchronously
    tb_sleep = 1'b1;
    wr(2, 2'b00, 18'h0_0001, "R7 write in sleep");
    rd(2, 2'b00, "R7 read in sleep");
    tb_sleep = 1'b0;
    rd(2, 2'b00, "R7 read after sleep");
    tb_sleep = 1'b1;
    rd(0, 2'b00, "R7 sleep async gate");
    tb_sleep = 1'b0;
    idle(3);

    // R9: pipelined mode
    pipe_mode = 1'b1;
    idle(3);
    rd(0, 2'b00, "R9 pipe read");
    rd(1, 2'b10, "R9 pipe lower");
    rd(2, 2'b01, "R9 pipe upper");
    wr(6, 2'b00, 18'h2_5A5A, "R9 pipe write");
    rd(6, 2'b00, "R9 pipe readback");
    rd(DEP - 1, 2'b01, "R9 pipe top row");
    idle(1);
    tb_oe_n = 1'b1;
    rd(3, 2'b00, "R6 pipe oe high");
    tb_oe_n = 1'b0;
    rd(4, 2'b00, "R9 pipe after oe");
    idle(3);
    pipe_mode = 1'b0;
    idle(3);
    rd(3, 2'b00, "R8 back to flow");
    idle(4);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule